// File: doc/BRIEF.md
# Seven-to-One Lane Serializer

This block turns a 28-bit parallel word into four serial data lanes and one forwarded-clock lane. It runs on a fast bit clock at seven times the word rate. A phase counter counts seven bit times per word period and captures a fresh word at phase 0. The 28 input bits are spread across the four lanes in a fixed, scrambled order, seven bit slots per lane. The clock lane repeats a pattern of four high bit times followed by three low bit times. Its rising edge lines up with the first slot of every lane, so a receiver can find the word boundary and recover the same assignment.

An active-low power-down input stops the link. While it is low, every lane output is forced low at once and no word is captured. When it is released, the first fast-clock edge captures a word and a new frame starts. A narrower 21-bit source ties input bits 21 to 27 to a constant, and those bits still occupy their slots.

Top module: `lane_serializer7`

## Requirements
- R1: A word is captured only at the rising fast-clock edge where the phase counter is 0, once every 7 fast clocks. Input changes at any other edge do not reach the lanes.
- R2: Slot k of a frame is driven during the k-th fast-clock period after the capturing edge (k = 0..6). Lane 0 (ser_data[0]) carries input bits 7, 6, 4, 3, 2, 1, 0 in slots 0 to 6.
- R3: Lane 1 (ser_data[1]) carries input bits 18, 15, 14, 13, 12, 9, 8 in slots 0 to 6.
- R4: Lane 2 (ser_data[2]) carries input bits 26, 25, 24, 22, 21, 20, 19 in slots 0 to 6.
- R5: Lane 3 (ser_data[3]) carries input bits 23, 17, 16, 11, 10, 5, 27 in slots 0 to 6.
- R6: The clock lane ser_clk is high in slots 0 to 3 and low in slots 4 to 6 of every active frame. Its rise lines up with slot 0 of the data lanes.
- R7: While pwr_n is 0, ser_data and ser_clk are 0, with no clock edge needed.
- R8: Words presented while pwr_n is 0 are never transmitted.
- R9: During reset and during power-down the phase counter is held at 0 and all outputs are low. The first edge after release with pwr_n at 1 captures a word.
- R10: All 28 bits are sent in every frame, including bits 21 to 27 when they are tied to a constant for a 21-bit source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock, seven times the word rate |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_n | input | 1 | Active-low power-down; 0 stops the link |
| word_in | input | 28 | Parallel word, captured at phase 0 |
| ser_data | output | 4 | Serial data lanes, one bit slot per fast clock |
| ser_clk | output | 1 | Forwarded-clock lane, 4 high / 3 low per frame |

## Verification
The hardest case to reach from the ports is a power-down that starts partway through a frame. The block has to drop its outputs at once, discard the half-sent word, and restart at phase 0 without mixing in stale data. The stimulus enters power-down in the middle of a frame and presents different words while it is held low. It then releases power-down and checks that the first frame carries only the word present at the release edge. Every frame also changes word_in right after the capturing edge, so any sampling at a phase other than 0 would show up in the lanes. A walking one through all 28 bits pins each bit to its lane and slot.

// File: rtl/lane_serializer7.sv
module lane_serializer7 #(
  parameter int LANES    = 4,
  parameter int SLOTS    = 7,
  parameter int CLK_HIGH = 4,
  parameter int IDXW     = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pwr_n,
  input  logic [LANES*SLOTS-1:0] word_in,
  output logic [LANES-1:0]       ser_data,
  output logic                   ser_clk
);
  localparam int WIDTH = LANES * SLOTS;
  localparam int PHW   = $clog2(SLOTS);
  localparam logic [SLOTS-1:0] CLK_PAT = SLOTS'(((1 << CLK_HIGH) - 1) << (SLOTS - CLK_HIGH));
  // lane-major, slot 0 first; entry e = lane*SLOTS+slot at [(WIDTH-1-e)*IDXW +: IDXW]
  localparam logic [WIDTH*IDXW-1:0] SLOT_MAP = {
    5'd7,  5'd6,  5'd4,  5'd3,  5'd2,  5'd1,  5'd0,
    5'd18, 5'd15, 5'd14, 5'd13, 5'd12, 5'd9,  5'd8,
    5'd26, 5'd25, 5'd24, 5'd22, 5'd21, 5'd20, 5'd19,
    5'd23, 5'd17, 5'd16, 5'd11, 5'd10, 5'd5,  5'd27
  };

  logic [PHW-1:0]   phase;
  logic [SLOTS-1:0] clk_sr;
  logic             load;

  assign load = (phase == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !pwr_n)              phase <= '0;
    else if (phase == PHW'(SLOTS - 1)) phase <= '0;
    else                               phase <= phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !pwr_n) clk_sr <= '0;
    else if (load)        clk_sr <= CLK_PAT;
    else                  clk_sr <= {clk_sr[SLOTS-2:0], 1'b0};
  end

  assign ser_clk = clk_sr[SLOTS-1] & pwr_n;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SLOTS-1:0] ld;
    logic [SLOTS-1:0] sr;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign ld[SLOTS-1-s] = word_in[SLOT_MAP[(WIDTH-1-(l*SLOTS+s))*IDXW +: IDXW]];
    end

    always_ff @(posedge clk) begin
      if (!rst_n || !pwr_n) sr <= '0;
      else if (load)        sr <= ld;
      else                  sr <= {sr[SLOTS-2:0], 1'b0};
    end

    assign ser_data[l] = sr[SLOTS-1] & pwr_n;

    // R2 R3 R4 R5: slot 0 of each lane carries its first mapped bit of the captured word
    a_r2_first_slot: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(pwr_n) && $past(load) && pwr_n)
        |-> ser_data[l] == $past(word_in[SLOT_MAP[(WIDTH-1-(l*SLOTS))*IDXW +: IDXW]]));
  end

  a_r1_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_n && phase == PHW'(SLOTS - 1)) |=> phase == '0);

  a_r1_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase < PHW'(SLOTS));

  a_r6_clk_lane: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_n |-> ser_clk == (phase >= PHW'(1) && phase <= PHW'(CLK_HIGH)));

  a_r7_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n |-> (ser_data == '0 && !ser_clk));

  a_r9_pd_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n |=> phase == '0);
endmodule

// File: tb/sim_lane_serializer7.sv
module sim_lane_serializer7;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_n = 1'b1;
  logic [27:0] word_in = '0;
  logic [3:0]  ser_data;
  logic        ser_clk;

  int checks = 0;
  int fails  = 0;

  int lane_map [4][7] = '{'{7, 6, 4, 3, 2, 1, 0},
                          '{18, 15, 14, 13, 12, 9, 8},
                          '{26, 25, 24, 22, 21, 20, 19},
                          '{23, 17, 16, 11, 10, 5, 27}};
  string lane_req [4] = '{"R2", "R3", "R4", "R5"};

  always #2 clk = ~clk;

  lane_serializer7 u0 (.clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .word_in(word_in),
                       .ser_data(ser_data), .ser_clk(ser_clk));

  function automatic logic exp_bit(input logic [27:0] w, input int l, input int k);
    return w[lane_map[l][k]];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // called at a negedge with the phase counter at 0
  task automatic send(input logic [27:0] w, input string tag);
    word_in = w;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      if (k == 0) word_in = 28'($urandom);
      for (int l = 0; l < 4; l++)
        check($sformatf("%s/%s slot%0d", tag, lane_req[l], k), 32'(ser_data[l]), 32'(exp_bit(w, l, k)));
      check($sformatf("R6 slot%0d", k), 32'(ser_clk), 32'(k < 4));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0007));
    repeat (3) @(negedge clk);
    check("R9 reset data", 32'(ser_data), 32'h0);
    check("R9 reset clk", 32'(ser_clk), 32'h0);
    rst_n = 1'b1;

    send(28'h0000000, "R1 zeros");
    send(28'hfffffff, "R1 ones");
    for (int b = 0; b < 28; b++) send(28'(1) << b, $sformatf("R1 walk%0d", b));
    for (int i = 0; i < 40; i++) send(28'($urandom), "R1 rand");
    for (int i = 0; i < 8; i++) send({7'h7f, 21'($urandom)}, "R10 hi21");
    for (int i = 0; i < 8; i++) send({7'h00, 21'($urandom)}, "R10 lo21");

    // mid-frame power-down
    word_in = 28'h5a5a5a5;
    repeat (3) @(negedge clk);
    pwr_n = 1'b0;
    #1;
    check("R7 pd data now", 32'(ser_data), 32'h0);
    check("R7 pd clk now", 32'(ser_clk), 32'h0);
    for (int i = 0; i < 10; i++) begin
      word_in = 28'($urandom);
      @(negedge clk);
      check("R8 pd data", 32'(ser_data), 32'h0);
      check("R7 pd clk", 32'(ser_clk), 32'h0);
    end
    pwr_n = 1'b1;
    send(28'h3c96e1d, "R9 restart");
    send(28'($urandom), "R8 after");

    // reset in mid-frame then restart
    word_in = 28'h1234567;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 mid reset data", 32'(ser_data), 32'h0);
    check("R9 mid reset clk", 32'(ser_clk), 32'h0);
    rst_n = 1'b1;
    send(28'h7654321, "R9 rst restart");

    summary();
    $finish;
  end
endmodule